// File: doc/BRIEF.md
# GPIO pad configuration controller

This block sits beside one chip pad and decides who drives it and how. It keeps a 13-bit configuration word for the pad. The word comes from a per-instance default on reset, and a management-side register write can replace it later. The word selects which side owns the pad: the management processor or the user logic. It also selects whether each digital buffer is on and which drive mode the pad uses. From the word and the live data and output-enable signals, the block produces the pad's output value and active-low output enable. It also produces the input-buffer disable and the 3-bit drive-mode code, and it returns the pad's input value to the side that may see it.

Each instance knows its own pin index through a parameter, and that index affects behaviour in two ways. Indices 0 to 5 always come out of reset under management control, whatever default is supplied, so the low pins stay reachable while the processor is held in reset. Management bidirectional operation is honoured only on indices 0, 1, 35, 36 and 37. On any other index the same word acts as a management output. A monitored user mode lets the user logic drive the pad while the management side still reads its level.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, the word is loaded with `DEFAULT_WORD` (default 13'h0403: management owner, output buffer off, input on, drive 001). Reset takes priority over a write in the same cycle.
- R2: On instances with `PIN_INDEX` below 6, bit 0 of the reset word is forced to 1 (management owner), whatever `DEFAULT_WORD` holds.
- R3: A write sets the word to `cfg_wdata` at the rising edge where `cfg_we` is high, and the outputs follow after that edge. With `cfg_we` low the word and the pad behaviour stay unchanged.
- R4: The word's fields are decoded as follows:
  - bit 0 = 1 gives management ownership.
  - bit 1 turns the output buffer off.
  - bit 3 turns the input buffer off and drives `pad_ibuf_dis`.
  - bits 12:10 appear unchanged on `pad_drive`: 000 analog, 001 input, 010 pull-down, 011 pull-up, 110 strong.
- R5: `pad_dout` equals `mgmt_dout` under management ownership and `user_dout` under user ownership.
- R6: When bit 1 is set and the word is not exactly 13'h1802, `pad_oeb` is 1 regardless of either side's OEB.
- R7: Under user ownership, with bit 1 clear and a non-zero drive code, `pad_oeb` follows `user_oeb`. This covers user output 13'h1808 and user bidirectional 13'h1800.
- R8: The word 13'h1802 is the monitored mode: `pad_oeb` follows `user_oeb`, `pad_dout` is `user_dout`, and both `user_din` and `mgmt_din` equal `pad_in`.
- R9: A management word with bits 1 and 3 clear and a non-zero drive code is bidirectional on indices 0, 1, 35, 36 and 37. There `pad_oeb` follows `mgmt_oeb` and the input buffer stays on.
- R10: The same word on any other index acts as a management output: `pad_oeb` = 0, `pad_ibuf_dis` = 1, `mgmt_din` = 0.
- R11: A management word with bit 1 clear, bit 3 set and a non-zero drive code holds `pad_oeb` at 0 whatever `mgmt_oeb` is.
- R12: A drive code of 000 (analog) gives `pad_oeb` = 1, `pad_ibuf_dis` = 1, `pad_drive` = 000, and both returned inputs at 0.
- R13: The owner's returned input equals `pad_in` while the input buffer is on and 0 otherwise. The non-owner's returned input is 0, except the management side in monitored mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 13 | Configuration word to write |
| mgmt_dout | input | 1 | Management output data |
| mgmt_oeb | input | 1 | Management output enable, active low |
| user_dout | input | 1 | User output data |
| user_oeb | input | 1 | User output enable, active low |
| pad_in | input | 1 | Level seen at the pad |
| pad_dout | output | 1 | Data sent to the pad driver |
| pad_oeb | output | 1 | Pad output enable, active low |
| pad_ibuf_dis | output | 1 | Pad input buffer disable |
| pad_drive | output | 3 | Pad drive-mode code |
| mgmt_din | output | 1 | Pad input returned to management |
| user_din | output | 1 | Pad input returned to user logic |

## Verification
All outputs are combinational from the stored word, so a corrupted word shows at the ports in the same cycle it is held. For a given input pattern it appears as a wrong owner on `pad_dout`, a wrong `pad_drive` code, or an input leaking to the wrong side. A write that is lost or misplaced becomes visible one edge after the strobe. A reset value that ignores the low-index rule shows up on the first cycle after reset as user data on the pad. A wrong index decision for bidirectional operation is seen only once a management bidirectional word has been written, as `pad_oeb` ignoring or following `mgmt_oeb`.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    localparam int CFG_W          = 13;
    localparam int DRV_W          = 3;
    localparam int BIT_OWNER      = 0;
    localparam int BIT_OBUF_OFF   = 1;
    localparam int BIT_IBUF_OFF   = 3;
    localparam int DRV_LSB        = 10;
    localparam int PROTECTED_PINS = 6;

    typedef logic [CFG_W-1:0] cfg_word_t;

    localparam logic [DRV_W-1:0] DRV_ANALOG = 3'b000;
    localparam logic [DRV_W-1:0] DRV_INPUT  = 3'b001;
    localparam logic [DRV_W-1:0] DRV_PULLDN = 3'b010;
    localparam logic [DRV_W-1:0] DRV_PULLUP = 3'b011;
    localparam logic [DRV_W-1:0] DRV_STRONG = 3'b110;

    // Recognised configuration words
    localparam cfg_word_t CFG_MGMT_IN_NOPULL = 13'h0403;
    localparam cfg_word_t CFG_MGMT_IN_PDN    = 13'h0803;
    localparam cfg_word_t CFG_MGMT_IN_PUP    = 13'h0c03;
    localparam cfg_word_t CFG_MGMT_OUT       = 13'h1809;
    localparam cfg_word_t CFG_MGMT_BIDIR     = 13'h1801;
    localparam cfg_word_t CFG_MGMT_ANALOG    = 13'h000b;
    localparam cfg_word_t CFG_USER_IN_NOPULL = 13'h0402;
    localparam cfg_word_t CFG_USER_IN_PDN    = 13'h0802;
    localparam cfg_word_t CFG_USER_IN_PUP    = 13'h0c02;
    localparam cfg_word_t CFG_USER_OUT       = 13'h1808;
    localparam cfg_word_t CFG_USER_BIDIR     = 13'h1800;
    localparam cfg_word_t CFG_USER_MONITOR   = 13'h1802;
    localparam cfg_word_t CFG_USER_ANALOG    = 13'h000a;

    typedef enum logic [1:0] {
        OE_FORCE_OFF  = 2'd0,
        OE_FORCE_ON   = 2'd1,
        OE_FROM_OWNER = 2'd2
    } oe_src_e;

    typedef struct packed {
        logic             mgmt_own;
        logic             obuf_off;
        logic             ibuf_off;
        logic [DRV_W-1:0] drive;
    } cfg_fields_t;

    typedef struct packed {
        logic             mgmt_own;
        logic             monitor;
        logic             ibuf_dis;
        oe_src_e          oe_src;
        logic [DRV_W-1:0] drive;
    } pad_ctl_t;

    function automatic cfg_fields_t split_word(input cfg_word_t w);
        cfg_fields_t f;
        f.mgmt_own = w[BIT_OWNER];
        f.obuf_off = w[BIT_OBUF_OFF];
        f.ibuf_off = w[BIT_IBUF_OFF];
        f.drive    = w[DRV_LSB +: DRV_W];
        return f;
    endfunction

    function automatic bit bidir_pin_ok(input int idx);
        return (idx == 0) || (idx == 1) || (idx == 35) || (idx == 36) || (idx == 37);
    endfunction

    function automatic cfg_word_t reset_word(input int idx, input cfg_word_t dflt);
        cfg_word_t w;
        w = dflt;
        if (idx < PROTECTED_PINS) w[BIT_OWNER] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/gpio_cfg_store.sv
module gpio_cfg_store
    import gpio_pad_pkg::*;
#(
    parameter int        PIN_INDEX    = 8,
    parameter cfg_word_t DEFAULT_WORD = CFG_MGMT_IN_NOPULL
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  cfg_word_t wdata,
    output cfg_word_t word
);

    localparam cfg_word_t RESET_WORD = reset_word(PIN_INDEX, DEFAULT_WORD);

    always_ff @(posedge clk) begin
        if (rst)     word <= RESET_WORD;
        else if (we) word <= wdata;
    end

    assert_reset_load_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (word == RESET_WORD));

    assert_write_R3: assert property (@(posedge clk) disable iff (rst)
        we |=> (word == $past(wdata)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(word));

    generate
        if (PIN_INDEX < PROTECTED_PINS) begin : g_protected
            assert_low_pin_mgmt_R2: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> word[BIT_OWNER]);
        end
    endgenerate

endmodule

// File: rtl/gpio_cfg_decode.sv
module gpio_cfg_decode
    import gpio_pad_pkg::*;
#(
    parameter int PIN_INDEX = 8
) (
    input  cfg_word_t word,
    output pad_ctl_t  ctl
);

    cfg_fields_t f;
    logic        analog;
    logic        monitor;
    logic        mgmt_bidir_req;
    logic        demote;

    assign f              = split_word(word);
    assign analog         = (f.drive == DRV_ANALOG);
    assign monitor        = (word == CFG_USER_MONITOR);
    assign mgmt_bidir_req = f.mgmt_own & ~f.obuf_off & ~f.ibuf_off & ~analog;

    // Pin index picks whether management bidirectional is honoured
    generate
        if (bidir_pin_ok(PIN_INDEX)) begin : g_bidir_pin
            assign demote = 1'b0;
        end else begin : g_plain_pin
            assign demote = mgmt_bidir_req;
        end
    endgenerate

    always_comb begin
        ctl.mgmt_own = f.mgmt_own;
        ctl.monitor  = monitor;
        ctl.drive    = f.drive;
        ctl.ibuf_dis = analog | f.ibuf_off | demote;
        if (analog || (f.obuf_off && !monitor))
            ctl.oe_src = OE_FORCE_OFF;
        else if (f.mgmt_own && (f.ibuf_off || demote))
            ctl.oe_src = OE_FORCE_ON;
        else
            ctl.oe_src = OE_FROM_OWNER;
    end

endmodule

// File: rtl/gpio_pad_route.sv
module gpio_pad_route
    import gpio_pad_pkg::*;
(
    input  pad_ctl_t         ctl,
    input  logic             mgmt_dout,
    input  logic             mgmt_oeb,
    input  logic             user_dout,
    input  logic             user_oeb,
    input  logic             pad_in,
    output logic             pad_dout,
    output logic             pad_oeb,
    output logic             pad_ibuf_dis,
    output logic [DRV_W-1:0] pad_drive,
    output logic             mgmt_din,
    output logic             user_din
);

    logic owner_oeb;
    logic in_live;

    assign owner_oeb    = ctl.mgmt_own ? mgmt_oeb : user_oeb;
    assign pad_dout     = ctl.mgmt_own ? mgmt_dout : user_dout;
    assign pad_ibuf_dis = ctl.ibuf_dis;
    assign pad_drive    = ctl.drive;
    assign in_live      = ~ctl.ibuf_dis & pad_in;
    assign mgmt_din     = in_live & (ctl.mgmt_own | ctl.monitor);
    assign user_din     = in_live & ~ctl.mgmt_own;

    always_comb begin
        case (ctl.oe_src)
            OE_FORCE_ON:   pad_oeb = 1'b0;
            OE_FROM_OWNER: pad_oeb = owner_oeb;
            default:       pad_oeb = 1'b1;
        endcase
    end

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int        PIN_INDEX    = 8,
    parameter cfg_word_t DEFAULT_WORD = CFG_MGMT_IN_NOPULL
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [12:0] cfg_wdata,
    input  logic        mgmt_dout,
    input  logic        mgmt_oeb,
    input  logic        user_dout,
    input  logic        user_oeb,
    input  logic        pad_in,
    output logic        pad_dout,
    output logic        pad_oeb,
    output logic        pad_ibuf_dis,
    output logic [2:0]  pad_drive,
    output logic        mgmt_din,
    output logic        user_din
);

    cfg_word_t cfg_q;
    pad_ctl_t  ctl;

    gpio_cfg_store #(
        .PIN_INDEX    (PIN_INDEX),
        .DEFAULT_WORD (DEFAULT_WORD)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .word  (cfg_q)
    );

    gpio_cfg_decode #(
        .PIN_INDEX (PIN_INDEX)
    ) u_decode (
        .word (cfg_q),
        .ctl  (ctl)
    );

    gpio_pad_route u_route (
        .ctl          (ctl),
        .mgmt_dout    (mgmt_dout),
        .mgmt_oeb     (mgmt_oeb),
        .user_dout    (user_dout),
        .user_oeb     (user_oeb),
        .pad_in       (pad_in),
        .pad_dout     (pad_dout),
        .pad_oeb      (pad_oeb),
        .pad_ibuf_dis (pad_ibuf_dis),
        .pad_drive    (pad_drive),
        .mgmt_din     (mgmt_din),
        .user_din     (user_din)
    );

    assert_obuf_off_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[BIT_OBUF_OFF] && cfg_q != CFG_USER_MONITOR) |-> pad_oeb);

    assert_analog_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[DRV_LSB +: DRV_W] == DRV_ANALOG) |->
            (pad_oeb && pad_ibuf_dis && !mgmt_din && !user_din));

    assert_monitor_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q == CFG_USER_MONITOR) |->
            (mgmt_din == pad_in && user_din == pad_in && pad_oeb == user_oeb));

    assert_user_blind_R13: assert property (@(posedge clk) disable iff (rst)
        cfg_q[BIT_OWNER] |-> !user_din);

    assert_mgmt_blind_R13: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q[BIT_OWNER] && cfg_q != CFG_USER_MONITOR) |-> !mgmt_din);

    generate
        if (!bidir_pin_ok(PIN_INDEX)) begin : g_demote_chk
            assert_demote_R10: assert property (@(posedge clk) disable iff (rst)
                (cfg_q == CFG_MGMT_BIDIR) |-> (!pad_oeb && pad_ibuf_dis && !mgmt_din));
        end else begin : g_bidir_chk
            assert_bidir_R9: assert property (@(posedge clk) disable iff (rst)
                (cfg_q == CFG_MGMT_BIDIR) |-> (pad_oeb == mgmt_oeb && !pad_ibuf_dis));
        end
    endgenerate

endmodule

// File: tb/sim_gpio_pad_ctrl.sv
module sim_gpio_pad_ctrl;
    import gpio_pad_pkg::*;

    localparam int NI = 3;
    localparam int IDX [NI] = '{20, 3, 36};
    localparam cfg_word_t DFLT [NI] = '{13'h1808, 13'h1808, 13'h0403};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, cfg_we;
    logic [12:0] cfg_wdata;
    logic        mgmt_dout, mgmt_oeb, user_dout, user_oeb, pad_in;

    logic       o_dout [NI];
    logic       o_oeb  [NI];
    logic       o_idis [NI];
    logic [2:0] o_drv  [NI];
    logic       o_mdin [NI];
    logic       o_udin [NI];

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    cfg_word_t word_m [NI];

    gpio_pad_ctrl #(.PIN_INDEX(20), .DEFAULT_WORD(13'h1808)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .mgmt_dout(mgmt_dout), .mgmt_oeb(mgmt_oeb), .user_dout(user_dout),
        .user_oeb(user_oeb), .pad_in(pad_in), .pad_dout(o_dout[0]),
        .pad_oeb(o_oeb[0]), .pad_ibuf_dis(o_idis[0]), .pad_drive(o_drv[0]),
        .mgmt_din(o_mdin[0]), .user_din(o_udin[0]));

    gpio_pad_ctrl #(.PIN_INDEX(3), .DEFAULT_WORD(13'h1808)) u1 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .mgmt_dout(mgmt_dout), .mgmt_oeb(mgmt_oeb), .user_dout(user_dout),
        .user_oeb(user_oeb), .pad_in(pad_in), .pad_dout(o_dout[1]),
        .pad_oeb(o_oeb[1]), .pad_ibuf_dis(o_idis[1]), .pad_drive(o_drv[1]),
        .mgmt_din(o_mdin[1]), .user_din(o_udin[1]));

    gpio_pad_ctrl #(.PIN_INDEX(36)) u2 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .mgmt_dout(mgmt_dout), .mgmt_oeb(mgmt_oeb), .user_dout(user_dout),
        .user_oeb(user_oeb), .pad_in(pad_in), .pad_dout(o_dout[2]),
        .pad_oeb(o_oeb[2]), .pad_ibuf_dis(o_idis[2]), .pad_drive(o_drv[2]),
        .mgmt_din(o_mdin[2]), .user_din(o_udin[2]));

    typedef struct packed {
        logic       dout;
        logic       oeb;
        logic       idis;
        logic [2:0] drv;
        logic       mdin;
        logic       udin;
    } exp_t;

    function automatic bit pin_bidir(input int idx);
        return idx == 0 || idx == 1 || idx == 35 || idx == 36 || idx == 37;
    endfunction

    // Reference behaviour built from the requirements
    function automatic exp_t model(input cfg_word_t w, input int idx);
        exp_t e;
        logic mg, od, id, an, mon, bok, idis;
        mg   = w[0];
        od   = w[1];
        id   = w[3];
        an   = (w[12:10] == 3'b000);
        mon  = (w == 13'h1802);
        bok  = pin_bidir(idx);
        idis = an | id | (mg & !od & !id & !bok);
        e.dout = mg ? mgmt_dout : user_dout;
        if (an || (od && !mon))  e.oeb = 1'b1;
        else if (mg)             e.oeb = (id || !bok) ? 1'b0 : mgmt_oeb;
        else                     e.oeb = user_oeb;
        e.idis = idis;
        e.drv  = w[12:10];
        e.mdin = (!idis && (mg || mon)) ? pad_in : 1'b0;
        e.udin = (!idis && !mg) ? pad_in : 1'b0;
        return e;
    endfunction

    function automatic string mode_tag(input cfg_word_t w, input int idx);
        if (w[12:10] == 3'b000)                 return "R12";
        if (w == 13'h1802)                      return "R8";
        if (w[1])                               return "R6";
        if (!w[0])                              return "R7";
        if (w[3])                               return "R11";
        return pin_bidir(idx) ? "R9" : "R10";
    endfunction

    function automatic cfg_word_t pick_word(input int sel);
        case (sel)
            0:  return CFG_MGMT_IN_NOPULL;
            1:  return CFG_MGMT_IN_PDN;
            2:  return CFG_MGMT_IN_PUP;
            3:  return CFG_MGMT_OUT;
            4:  return CFG_MGMT_BIDIR;
            5:  return CFG_MGMT_ANALOG;
            6:  return CFG_USER_IN_NOPULL;
            7:  return CFG_USER_IN_PDN;
            8:  return CFG_USER_IN_PUP;
            9:  return CFG_USER_OUT;
            10: return CFG_USER_BIDIR;
            11: return CFG_USER_MONITOR;
            12: return CFG_USER_ANALOG;
            default: return cfg_word_t'($urandom);
        endcase
    endfunction

    task automatic chk(input int k, input string tag, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s u%0d %s: actual=%0h expected=%0h (word=%h)",
                     tag, k, what, act, exp, word_m[k]);
        end
    endtask

    task automatic check_all(input string force_tag);
        for (int k = 0; k < NI; k++) begin
            exp_t  e;
            string mt;
            e  = model(word_m[k], IDX[k]);
            mt = (force_tag != "") ? force_tag : mode_tag(word_m[k], IDX[k]);
            chk(k, (force_tag != "") ? force_tag : "R5", "pad_dout", {3'b0, o_dout[k]}, {3'b0, e.dout});
            chk(k, mt, "pad_oeb", {3'b0, o_oeb[k]}, {3'b0, e.oeb});
            chk(k, (force_tag != "") ? force_tag : "R4", "pad_ibuf_dis", {3'b0, o_idis[k]}, {3'b0, e.idis});
            chk(k, (force_tag != "") ? force_tag : "R4", "pad_drive", {1'b0, o_drv[k]}, {1'b0, e.drv});
            chk(k, (force_tag != "") ? force_tag : "R13", "mgmt_din", {3'b0, o_mdin[k]}, {3'b0, e.mdin});
            chk(k, (force_tag != "") ? force_tag : "R13", "user_din", {3'b0, o_udin[k]}, {3'b0, e.udin});
        end
    endtask

    task automatic load_reset_model();
        for (int k = 0; k < NI; k++) begin
            word_m[k] = DFLT[k];
            if (IDX[k] < 6) word_m[k][0] = 1'b1;
        end
    endtask

    task automatic write_word(input cfg_word_t w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(posedge clk);
        for (int k = 0; k < NI; k++) word_m[k] = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
        mgmt_dout = 1'b0; mgmt_oeb = 1'b1; user_dout = 1'b0; user_oeb = 1'b1; pad_in = 1'b0;
        repeat (3) @(posedge clk);
        load_reset_model();
        @(negedge clk);
        rst = 1'b0;
        // R1 (u0, u2) and R2 (u1 low index forced to management)
        for (int p = 0; p < 8; p++) begin
            {mgmt_oeb, user_oeb, pad_in} = 3'(p);
            mgmt_dout = p[0]; user_dout = ~p[0];
            #1;
            check_all("");
            chk(1, "R2", "owner after reset", {3'b0, o_dout[1]}, {3'b0, mgmt_dout});
            chk(0, "R1", "default user output oeb", {3'b0, o_oeb[0]}, {3'b0, user_oeb});
            chk(2, "R1", "default mgmt in mdin", {3'b0, o_mdin[2]}, {3'b0, pad_in});
            @(negedge clk);
        end

        // Directed: every recognised word with all OEB/pad patterns
        for (int s = 0; s < 13; s++) begin
            write_word(pick_word(s));
            for (int p = 0; p < 32; p++) begin
                {mgmt_dout, user_dout, mgmt_oeb, user_oeb, pad_in} = 5'(p);
                #1;
                check_all("");
                @(negedge clk);
            end
        end

        // R3: no write, changing wdata must not alter behaviour
        write_word(CFG_USER_BIDIR);
        for (int i = 0; i < 6; i++) begin
            cfg_wdata = cfg_word_t'($urandom);
            {mgmt_dout, user_dout, mgmt_oeb, user_oeb, pad_in} = 5'($urandom);
            #1;
            check_all("R3");
            @(negedge clk);
        end

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            cfg_we    = ($urandom_range(0, 3) == 0);
            cfg_wdata = pick_word($urandom_range(0, 16));
            {mgmt_dout, user_dout, mgmt_oeb, user_oeb, pad_in} = 5'($urandom);
            #1;
            check_all("");
            @(posedge clk);
            if (cfg_we) for (int k = 0; k < NI; k++) word_m[k] = cfg_wdata;
        end

        // R1: reset wins over a simultaneous write
        @(negedge clk);
        rst = 1'b1; cfg_we = 1'b1; cfg_wdata = CFG_USER_ANALOG;
        @(posedge clk);
        load_reset_model();
        @(negedge clk);
        rst = 1'b0; cfg_we = 1'b0;
        for (int p = 0; p < 8; p++) begin
            {user_oeb, mgmt_oeb, pad_in} = 3'(p);
            #1;
            check_all("R1");
            @(negedge clk);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule